// File: doc/BRIEF.md
# Instruction-Cache Refill Coordinator

This controller sits at the centre of an instruction cache whose data is split across several independent slices. It is the only holder of the tag and status bits for every cache line. Each set has two ways, and the cache keeps one victim bit per set. A fetch lookup presents a line address and gets one of three answers in the same cycle: hit, busy or miss.

A miss claims a way at once. The controller writes the new tag into that way and marks the line pending. On the next cycle it sends the line address to every slice on one shared refill strobe. Each slice then fetches its own part of the line from second-level memory, in its own time, and pulses its done input when finished. The controller gathers these pulses in any order. When the last one arrives, it marks the line valid and issues a one-cycle dispatch permit that carries the line address.

Only one refill can be in flight at a time. A second miss that arrives during a refill is answered busy, and the fetch side must retry it later.

Top module: `icache_refill_ctrl`

## Requirements
- R1: After reset, every line is invalid, and both `refill_req` and `dispatch_ok` are low. The first lookup of any address reports miss.
- R2: A lookup accepted as a miss makes `refill_req` high for exactly one cycle, on the cycle after the lookup. During that cycle `refill_addr` equals the looked-up address. The line address is `{tag, index}`, with the set index in the low `IDX_W` bits.
- R3: While a refill is in flight, a lookup that misses a valid line reports busy, not miss, and does not start a second refill. At most one line is pending at any time.
- R4: A lookup of the line that is being refilled reports busy. Exactly one of hit, busy or miss is high for each valid lookup.
- R5: `dispatch_ok` stays low until done has been seen from every slice. It is high for exactly one cycle, on the cycle after the last missing done is sampled. During that cycle `dispatch_addr` carries the refilled address.
- R6: Slices may report done in any order. A repeated done from a slice that has already reported has no effect.
- R7: A refilled line reports hit only after its dispatch permit has been issued.
- R8: During a refill, lookups of other lines that are valid still report hit.
- R9: On a miss, the victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way named by the set's victim bit. A hit sets the victim bit to the other way. A fill sets the victim bit to the way that was not filled.
- R10: Done pulses that arrive while no refill is in flight are ignored. They produce no permit and do not count toward the next refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | TAG_W+IDX_W | Line address looked up |
| lkp_hit | output | 1 | Line present and valid |
| lkp_busy | output | 1 | Lookup must retry; a refill is in flight |
| lkp_miss | output | 1 | Miss accepted; a refill starts |
| refill_req | output | 1 | Refill strobe, seen by all slices |
| refill_addr | output | TAG_W+IDX_W | Line address to refill |
| slice_done | input | NUM_SLICES | Per-slice refill completion pulses |
| dispatch_ok | output | 1 | Permit to dispatch the refilled line |
| dispatch_addr | output | TAG_W+IDX_W | Address carried by the permit |

## Verification
The bench builds the block with five slices, `IDX_W`=2 and `TAG_W`=4. That gives 64 distinct lines in four sets of two ways. A sweep over every address, first in ascending and then in descending order, fills every set and evicts from it many times, so each victim-choice branch is exercised. Slice done order is rotated through steps 1 to 4 at varying offsets, with random gaps and one duplicate pulse per refill. Busy, hit-during-refill and idle-done cases are probed inside every refill.

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl #(
  parameter int NUM_SLICES = 5,
  parameter int IDX_W      = 2,
  parameter int TAG_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lkp_valid,
  input  logic [TAG_W+IDX_W-1:0] lkp_addr,
  output logic                   lkp_hit,
  output logic                   lkp_busy,
  output logic                   lkp_miss,
  output logic                   refill_req,
  output logic [TAG_W+IDX_W-1:0] refill_addr,
  input  logic [NUM_SLICES-1:0]  slice_done,
  output logic                   dispatch_ok,
  output logic [TAG_W+IDX_W-1:0] dispatch_addr
);
  localparam int SETS   = 1 << IDX_W;
  localparam int ADDR_W = TAG_W + IDX_W;

  logic [TAG_W-1:0]      tag_q [2*SETS];
  logic [2*SETS-1:0]     vld_q, pend_q;
  logic [SETS-1:0]       lru_q;
  logic                  active_q, rf_way_q, req_q, disp_q;
  logic [NUM_SLICES-1:0] done_q;
  logic [ADDR_W-1:0]     rf_addr_q;

  wire [IDX_W-1:0] idx = lkp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] tg  = lkp_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] ridx = rf_addr_q[IDX_W-1:0];

  wire eq0 = tag_q[{idx, 1'b0}] == tg;
  wire eq1 = tag_q[{idx, 1'b1}] == tg;
  wire m0  = vld_q[{idx, 1'b0}] && eq0;
  wire m1  = vld_q[{idx, 1'b1}] && eq1;
  wire pm  = (pend_q[{idx, 1'b0}] && eq0) || (pend_q[{idx, 1'b1}] && eq1);
  wire all_done = &(done_q | slice_done);

  logic vic;
  always_comb begin
    if (!vld_q[{idx, 1'b0}])      vic = 1'b0;
    else if (!vld_q[{idx, 1'b1}]) vic = 1'b1;
    else                          vic = lru_q[idx];
  end

  assign lkp_hit       = lkp_valid && (m0 || m1);
  assign lkp_busy      = lkp_valid && !(m0 || m1) && (active_q || pm);
  assign lkp_miss      = lkp_valid && !(m0 || m1) && !active_q && !pm;
  assign refill_req    = req_q;
  assign refill_addr   = rf_addr_q;
  assign dispatch_ok   = disp_q;
  assign dispatch_addr = rf_addr_q;

  always_ff @(posedge clk)
    if (lkp_miss) tag_q[{idx, vic}] <= tg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      pend_q    <= '0;
      lru_q     <= '0;
      active_q  <= 1'b0;
      rf_way_q  <= 1'b0;
      req_q     <= 1'b0;
      disp_q    <= 1'b0;
      done_q    <= '0;
      rf_addr_q <= '0;
    end else begin
      req_q  <= 1'b0;
      disp_q <= 1'b0;
      if (lkp_hit) lru_q[idx] <= m0;
      if (lkp_miss) begin
        vld_q[{idx, vic}]  <= 1'b0;
        pend_q[{idx, vic}] <= 1'b1;
        active_q  <= 1'b1;
        done_q    <= '0;
        rf_addr_q <= lkp_addr;
        rf_way_q  <= vic;
        req_q     <= 1'b1;
      end else if (active_q) begin
        if (all_done) begin
          active_q <= 1'b0;
          vld_q[{ridx, rf_way_q}]  <= 1'b1;
          pend_q[{ridx, rf_way_q}] <= 1'b0;
          lru_q[ridx] <= !rf_way_q;
          disp_q   <= 1'b1;
        end else begin
          done_q <= done_q | slice_done;
        end
      end
    end
  end

  // R2
  refill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |=> !refill_req);
  // R2
  refill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_miss |=> (refill_req && refill_addr == $past(lkp_addr)));
  // R3
  one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_q) <= 1);
  // R4
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lkp_hit, lkp_busy, lkp_miss}));
  // R5
  dispatch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !lkp_miss && !(&(done_q | slice_done))) |=> !dispatch_ok);
  // R5
  dispatch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_ok |=> !dispatch_ok);
endmodule

// File: tb/test_icache_refill_ctrl.sv
module test_icache_refill_ctrl;
  localparam int NS = 5, IW = 2, TW = 4, SETS = 1 << IW, AW = TW + IW;

  logic clk = 0, rst_n = 0, lkp_valid = 0;
  logic [AW-1:0] lkp_addr = '0;
  logic [NS-1:0] slice_done = '0;
  logic lkp_hit, lkp_busy, lkp_miss, refill_req, dispatch_ok;
  logic [AW-1:0] refill_addr, dispatch_addr;

  icache_refill_ctrl #(.NUM_SLICES(NS), .IDX_W(IW), .TAG_W(TW)) i_icache_refill_ctrl (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .lkp_hit(lkp_hit), .lkp_busy(lkp_busy), .lkp_miss(lkp_miss),
    .refill_req(refill_req), .refill_addr(refill_addr), .slice_done(slice_done),
    .dispatch_ok(dispatch_ok), .dispatch_addr(dispatch_addr));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_refill = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [TW-1:0] m_tag [SETS][2];
  logic m_vld [SETS][2];
  logic m_lru [SETS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return int'(lfsr);
  endfunction

  function automatic int find_way(input logic [AW-1:0] a);
    for (int w = 0; w < 2; w++)
      if (m_vld[a[IW-1:0]][w] && m_tag[a[IW-1:0]][w] == a[AW-1:IW]) return w;
    return -1;
  endfunction

  task automatic probe(input logic [AW-1:0] a, input int exp, input string req);
    int w;
    @(negedge clk);
    lkp_valid = 1; lkp_addr = a;
    #1;
    check({lkp_hit, lkp_busy, lkp_miss} == exp[2:0], req, {lkp_hit, lkp_busy, lkp_miss}, exp);
    if (exp == 4) begin
      w = find_way(a);
      m_lru[a[IW-1:0]] = (w == 0);
    end
    @(posedge clk); #1;
    lkp_valid = 0;
  endtask

  task automatic refill(input logic [AW-1:0] a, input int way);
    int step, off, sl, prev, s2, t2;
    logic [AW-1:0] other;
    @(negedge clk); #1;
    check(refill_req && refill_addr == a, "R2", refill_addr, a);
    probe(a, 2, "R4");
    check(!refill_req, "R2", refill_req, 0);
    s2 = (a[IW-1:0] + 1) % SETS;
    t2 = 0;
    for (int t = 0; t < (1 << TW); t++)
      if (find_way({t[TW-1:0], s2[IW-1:0]}) < 0) t2 = t;
    probe({t2[TW-1:0], s2[IW-1:0]}, 2, "R3");
    other = '0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++)
        if (m_vld[s][w]) other = {m_tag[s][w], s[IW-1:0]};
    if (find_way(other) >= 0) probe(other, 4, "R8");
    step = 1 + (n_refill % 4);
    off = (n_refill / 4) % NS;
    prev = 0;
    for (int k = 0; k < NS; k++) begin
      sl = (off + k * step) % NS;
      repeat (rnd() % 3) begin
        @(negedge clk); #1;
        check(!dispatch_ok, "R5", dispatch_ok, 0);
      end
      @(negedge clk);
      slice_done = '0;
      slice_done[sl] = 1'b1;
      if (k == 1) slice_done[prev] = 1'b1;
      prev = sl;
      @(negedge clk);
      slice_done = '0;
      #1;
      if (k < NS - 1) check(!dispatch_ok, "R6", dispatch_ok, 0);
      else check(dispatch_ok && dispatch_addr == a, "R5", dispatch_addr, a);
      if (k == NS - 2) begin
        lkp_valid = 1; lkp_addr = a; #1;
        check(lkp_busy, "R7", lkp_hit, 0);
        lkp_valid = 0;
      end
    end
    m_vld[a[IW-1:0]][way] = 1;
    m_lru[a[IW-1:0]] = !way[0];
    @(negedge clk); #1;
    check(!dispatch_ok, "R5", dispatch_ok, 0);
    n_refill++;
  endtask

  task automatic access(input logic [AW-1:0] a);
    int s, w, v;
    s = a[IW-1:0];
    w = find_way(a);
    if (w >= 0) begin
      probe(a, 4, "R7");
    end else begin
      v = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : int'(m_lru[s]));
      probe(a, 1, "R1");
      m_tag[s][v] = a[AW-1:IW];
      m_vld[s][v] = 0;
      refill(a, v);
      for (int ww = 0; ww < 2; ww++)
        if (ww != v) check(find_way(a) == v, "R9", find_way(a), v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_vld[s][w] = 0; m_tag[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(!refill_req && !dispatch_ok, "R1", {refill_req, dispatch_ok}, 0);
    @(negedge clk); slice_done = '1;
    @(negedge clk); slice_done = '0; #1;
    check(!dispatch_ok, "R10", dispatch_ok, 0);
    for (int t = 0; t < (1 << TW); t++)
      for (int s = 0; s < SETS; s++) access({t[TW-1:0], s[IW-1:0]});
    for (int i = (1 << AW) - 1; i >= 0; i--) access(i[AW-1:0]);
    for (int i = 0; i < 40; i++) access(AW'(rnd()));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule